// File: doc/BRIEF.md
# SCSI Controller Command Gate

This block sits behind the command register of a SCSI protocol controller. A host writes one command byte at a time; the gate sorts the opcode into a group, checks that group against the controller's connection state and the bus phase, and either launches the command towards the sequencer with a one-cycle start strobe or refuses it and raises the illegal-command interrupt cause. A refused command changes nothing else.

The gate keeps the connection state (idle, selecting, linked to a target as initiator), an eight-cause interrupt register with a derived pending bit in the status register, and a configuration byte. The downstream sequencer is represented only by its `seq_done` and `seq_disc` inputs, and the bus phase arrives on `phase_in`. Host access uses a two-bit register select: 0 command (write launches, read returns the last accepted byte), 1 status, 2 interrupt, 3 configuration.

Top module: `scg_cmd_gate`

## Requirements
- R1: After reset the interrupt register reads 0, the status pending bit is 0, the gate is idle and `cmd_start` is low.
- R2: Opcodes 0x00 (no-op), 0x01 (flush), 0x02 (chip reset) and 0x03 (bus reset) are accepted in every state, and no-op and flush set no interrupt cause.
- R3: An accepted bus reset returns the gate to idle and sets interrupt bit 7 unless configuration bit 6 is 1.
- R4: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are accepted only while linked.
- R5: Opcodes 0x20 through 0x2B are accepted only while linked and `phase_in` is 3'b110 or 3'b111 (message bit 2 and control bit 1 both set).
- R6: Opcodes 0x40 through 0x47 are accepted only while not linked; all of them except 0x44 and 0x45 move the gate to selecting.
- R7: Bit 7 of the written byte is the DMA request: it is removed before the group check and reported on `cmd_dma` beside the 7-bit `cmd_op`.
- R8: A command refused by its group check, or with any opcode not listed in R2, R4, R5 or R6, sets interrupt bit 6, raises no start strobe and leaves the state unchanged.
- R9: An accepted command raises `cmd_start` for exactly the one cycle after the write edge, with `cmd_op` and `cmd_dma` valid in that cycle.
- R10: A read of register 2 returns the interrupt register and clears every bit at that edge, except causes arriving in the same cycle; status bit 7 is 1 exactly when any interrupt bit is set and status bits 2:0 mirror `phase_in`.
- R11: An accepted chip reset returns the gate to idle and clears the interrupt register at that edge.
- R12: `seq_done` sets interrupt bit 3 and, while selecting, moves the gate to linked.
- R13: `seq_disc` returns the gate to idle from any state and sets interrupt bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects only; data is always driven) |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register |
| phase_in | input | 3 | Current bus phase, bit 2 message, bit 1 control, bit 0 direction |
| seq_done | input | 1 | Sequencer finished a function |
| seq_disc | input | 1 | Target dropped the connection |
| cmd_start | output | 1 | One-cycle launch strobe for an accepted command |
| cmd_op | output | 7 | Opcode of the launched command |
| cmd_dma | output | 1 | DMA request of the launched command |

## Verification
Every result of this block appears one clock edge after its cause: the start strobe, opcode and DMA flag in the cycle following the write edge, and new interrupt bits, clears and state changes visible on the read port from that same following cycle. Read data is combinational, so the interrupt and status values are compared in the half cycle before the edge that performs the read, and the strobe outputs one nanosecond after the edge. Connection state has no port of its own; it is observed through which later commands are accepted or refused.

// File: rtl/scg_pkg.sv
package scg_pkg;

    localparam int DATA_W  = 8;
    localparam int OP_W    = DATA_W - 1;
    localparam int ADDR_W  = 2;
    localparam int NCAUSE  = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD  = 2'd0,
        REG_STAT = 2'd1,
        REG_INTR = 2'd2,
        REG_CFG  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        GRP_ANY,
        GRP_LINK,
        GRP_MSG,
        GRP_IDLE,
        GRP_BAD
    } grp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECTING,
        ST_LINKED
    } conn_e;

    localparam int IRQ_DONE   = 3;
    localparam int IRQ_DISC   = 5;
    localparam int IRQ_ILLCMD = 6;
    localparam int IRQ_BUSRST = 7;
    localparam int CFG_MUTE_BUSRST = 6;

    typedef struct packed {
        logic legal;
        logic chip_rst;
        logic bus_rst;
        logic arm_sel;
    } verdict_t;

    function automatic grp_e op_group(input logic [OP_W-1:0] op);
        grp_e g;
        case (op)
            7'h00, 7'h01, 7'h02, 7'h03:                      g = GRP_ANY;
            7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B:        g = GRP_LINK;
            default: begin
                if (op >= 7'h20 && op <= 7'h2B)              g = GRP_MSG;
                else if (op >= 7'h40 && op <= 7'h47)         g = GRP_IDLE;
                else                                         g = GRP_BAD;
            end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/scg_decode.sv
module scg_decode
    import scg_pkg::*;
(
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  conn_e             state,
    input  logic [2:0]        phase,
    output grp_e              group,
    output verdict_t          verdict,
    output logic              accept,
    output logic              illegal,
    output logic [OP_W-1:0]   op,
    output logic              dma
);
    logic linked;
    logic msg_phase;

    always_comb begin
        op        = wdata[OP_W-1:0];
        dma       = wdata[DATA_W-1];
        group     = op_group(op);
        linked    = (state == ST_LINKED);
        msg_phase = phase[2] & phase[1];

        verdict          = '0;
        verdict.chip_rst = (op == 7'h02);
        verdict.bus_rst  = (op == 7'h03);
        verdict.arm_sel  = (group == GRP_IDLE) && (op != 7'h44) && (op != 7'h45);
        case (group)
            GRP_ANY:  verdict.legal = 1'b1;
            GRP_LINK: verdict.legal = linked;
            GRP_MSG:  verdict.legal = linked && msg_phase;
            GRP_IDLE: verdict.legal = !linked;
            default:  verdict.legal = 1'b0;
        endcase

        accept  = wr_cmd && verdict.legal;
        illegal = wr_cmd && !verdict.legal;
    end
endmodule

// File: rtl/scg_conn.sv
module scg_conn
    import scg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  verdict_t verdict,
    input  logic     seq_done,
    input  logic     seq_disc,
    output conn_e    state
);
    conn_e state_d;

    always_comb begin
        state_d = state;
        if (seq_disc)
            state_d = ST_IDLE;
        else if (accept && (verdict.chip_rst || verdict.bus_rst))
            state_d = ST_IDLE;
        else if (seq_done && state == ST_SELECTING)
            state_d = ST_LINKED;
        else if (accept && verdict.arm_sel)
            state_d = ST_SELECTING;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/scg_intr.sv
module scg_intr #(
    parameter int NCAUSE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic [NCAUSE-1:0] set_vec,
    output logic [NCAUSE-1:0] intr_q
);
    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst)
                intr_q[i] <= 1'b0;
            else
                intr_q[i] <= (intr_q[i] & ~clr_all) | set_vec[i];
        end
    end
endmodule

// File: rtl/scg_cmd_gate.sv
module scg_cmd_gate
    import scg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [2:0]        phase_in,
    input  logic              seq_done,
    input  logic              seq_disc,
    output logic              cmd_start,
    output logic [OP_W-1:0]   cmd_op,
    output logic              cmd_dma
);
    conn_e             state;
    grp_e              group;
    verdict_t          verdict;
    logic              accept, illegal, dma;
    logic [OP_W-1:0]   op;
    logic [NCAUSE-1:0] intr_q, set_vec;
    logic              clr_all, brst_set, wr_cmd, rd_intr;
    logic [DATA_W-1:0] cfg_q, last_cmd_q;

    assign wr_cmd  = host_wr && (host_addr == REG_CMD);
    assign rd_intr = host_rd && (host_addr == REG_INTR);

    scg_decode u_dec (
        .wr_cmd (wr_cmd),
        .wdata  (host_wdata),
        .state  (state),
        .phase  (phase_in),
        .group  (group),
        .verdict(verdict),
        .accept (accept),
        .illegal(illegal),
        .op     (op),
        .dma    (dma)
    );

    scg_conn u_conn (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .verdict (verdict),
        .seq_done(seq_done),
        .seq_disc(seq_disc),
        .state   (state)
    );

    assign brst_set = accept && verdict.bus_rst && !cfg_q[CFG_MUTE_BUSRST];
    assign clr_all  = rd_intr || (accept && verdict.chip_rst);

    always_comb begin
        set_vec             = '0;
        set_vec[IRQ_DONE]   = seq_done;
        set_vec[IRQ_DISC]   = seq_disc;
        set_vec[IRQ_ILLCMD] = illegal;
        set_vec[IRQ_BUSRST] = brst_set;
    end

    scg_intr #(.NCAUSE(NCAUSE)) u_intr (
        .clk    (clk),
        .rst    (rst),
        .clr_all(clr_all),
        .set_vec(set_vec),
        .intr_q (intr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            last_cmd_q <= '0;
            cmd_start  <= 1'b0;
            cmd_op     <= '0;
            cmd_dma    <= 1'b0;
        end else begin
            cmd_start <= accept;
            if (accept) begin
                cmd_op     <= op;
                cmd_dma    <= dma;
                last_cmd_q <= host_wdata;
            end
            if (host_wr && host_addr == REG_CFG)
                cfg_q <= host_wdata;
        end
    end

    always_comb begin
        case (host_addr)
            REG_CMD:  host_rdata = last_cmd_q;
            REG_STAT: host_rdata = {(|intr_q), 4'b0000, phase_in};
            REG_INTR: host_rdata = intr_q;
            default:  host_rdata = cfg_q;
        endcase
    end
endmodule

// File: rtl/scg_checker.sv
module scg_checker
    import scg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              accept,
    input logic              illegal,
    input verdict_t          verdict,
    input grp_e              group,
    input conn_e             state,
    input logic              seq_done,
    input logic              seq_disc,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [NCAUSE-1:0] intr_q,
    input logic              cmd_start
);
    assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (intr_q[IRQ_ILLCMD] && !cmd_start));

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(accept));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == REG_INTR && !accept && !illegal && !seq_done && !seq_disc)
        |=> (intr_q == '0));

    assert_chip_reset_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && verdict.chip_rst && !seq_done && !seq_disc)
        |=> (intr_q == '0 && state == ST_IDLE));

    assert_disc_R13: assert property (@(posedge clk) disable iff (rst)
        seq_disc |=> (state == ST_IDLE && intr_q[IRQ_DISC]));

    assert_idle_group_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && group == GRP_IDLE) |-> (state != ST_LINKED));
endmodule

bind scg_cmd_gate scg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .illegal  (illegal),
    .verdict  (verdict),
    .group    (group),
    .state    (state),
    .seq_done (seq_done),
    .seq_disc (seq_disc),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .intr_q   (intr_q),
    .cmd_start(cmd_start)
);

// File: tb/scg_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module scg_cmd_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [2:0] phase_in = '0;
    logic       seq_done = 1'b0, seq_disc = 1'b0;
    logic       cmd_start, cmd_dma;
    logic [6:0] cmd_op;

    always #2.5 clk = ~clk;

    scg_cmd_gate dut_i (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phase_in(phase_in), .seq_done(seq_done), .seq_disc(seq_disc),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_dma(cmd_dma)
    );

    int         nvec = 0, nbad = 0;
    bit         done_flag = 0;
    int         m_st = 0;        // 0 idle, 1 selecting, 2 linked
    logic [7:0] m_intr = '0, m_cfg = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 any state, 1 linked, 2 linked + message phase, 3 not linked, 4 undefined
    function automatic int grp_of(input logic [6:0] op);
        if (op <= 7'h03) return 0;
        if (op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h18 || op == 7'h1A || op == 7'h1B) return 1;
        if (op >= 7'h20 && op <= 7'h2B) return 2;
        if (op >= 7'h40 && op <= 7'h47) return 3;
        return 4;
    endfunction

    task automatic step(input logic wr, input logic [1:0] addr, input logic [7:0] wd,
                        input logic rd, input logic dn, input logic dc, input string tag);
        logic       exp_start, clr, legal;
        logic [7:0] nw;
        logic [6:0] op;
        int         g, nst;
        @(negedge clk);
        host_wr = wr; host_addr = addr; host_wdata = wd; host_rd = rd;
        seq_done = dn; seq_disc = dc;
        #1;
        if (rd && addr == 2'd2) chk({tag, " R10 intr read"}, host_rdata, m_intr);
        if (rd && addr == 2'd1) chk({tag, " R10 status"}, host_rdata, {(m_intr != 0), 4'b0, phase_in});
        exp_start = 1'b0; nw = '0; clr = rd && addr == 2'd2; nst = m_st;
        op = wd[6:0];
        if (wr && addr == 2'd0) begin
            g = grp_of(op);
            legal = (g == 0) || (g == 1 && m_st == 2) ||
                    (g == 2 && m_st == 2 && phase_in[2] && phase_in[1]) ||
                    (g == 3 && m_st != 2);
            if (legal) begin
                exp_start = 1'b1;
                if (op == 7'h02) begin clr = 1'b1; nst = 0; end
                if (op == 7'h03) begin nst = 0; if (!m_cfg[6]) nw[7] = 1'b1; end
                if (g == 3 && op != 7'h44 && op != 7'h45) nst = 1;
            end else nw[6] = 1'b1;
        end
        if (wr && addr == 2'd3) m_cfg = wd;
        if (dn) begin nw[3] = 1'b1; if (m_st == 1) nst = 2; end
        if (dc) begin nw[5] = 1'b1; nst = 0; end
        @(posedge clk);
        #1;
        m_intr = (clr ? 8'h00 : m_intr) | nw;
        m_st = nst;
        chk({tag, " R9 start"}, cmd_start, exp_start);
        if (exp_start) begin
            chk({tag, " R7 op"}, cmd_op, op);
            chk({tag, " R7 dma"}, cmd_dma, wd[7]);
        end
        host_wr = 0; host_rd = 0; seq_done = 0; seq_disc = 0;
    endtask

    task automatic cmd(input logic [7:0] b, input string tag);
        step(1, 2'd0, b, 0, 0, 0, tag);
    endtask
    task automatic rd_intr(input string tag);
        step(0, 2'd2, 8'h00, 1, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] picks [12];
        void'($urandom(32'h5C6A));
        picks = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h1B, 8'h25, 8'h2B, 8'h41, 8'h44, 8'h47, 8'h2C};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 start low", cmd_start, 1'b0);
        rd_intr("R1");
        step(0, 2'd1, 8'h00, 1, 0, 0, "R1");
        // R4 / R8: linked-only command while idle
        cmd(8'h10, "R4 R8 idle");
        rd_intr("R8");
        rd_intr("R10 cleared");
        // R2: no-op and flush
        cmd(8'h00, "R2 nop"); cmd(8'h81, "R2 flush");
        rd_intr("R2 none");
        // R7 / R6 / R12: select with DMA, then done
        cmd(8'hC2, "R7 R6 select");
        step(0, 2'd0, 8'h00, 0, 1, 0, "R12 done");
        rd_intr("R12");
        cmd(8'h10, "R4 linked");
        phase_in = 3'b000;
        cmd(8'h28, "R5 wrong phase");
        phase_in = 3'b111;
        cmd(8'h28, "R5 msg phase");
        phase_in = 3'b110;
        cmd(8'hA0, "R5 msg out");
        cmd(8'h41, "R6 refused linked");
        rd_intr("R8 R6");
        // R3 bus reset reporting
        cmd(8'h03, "R3 busrst");
        rd_intr("R3 flag");
        cmd(8'h10, "R3 idle after");
        step(1, 2'd3, 8'h40, 0, 0, 0, "R3 cfg");
        cmd(8'h03, "R3 muted");
        rd_intr("R3 muted");
        // R13 disconnect
        cmd(8'h42, "R13 sel");
        step(0, 2'd0, 8'h00, 0, 1, 0, "R13 done");
        step(0, 2'd0, 8'h00, 0, 0, 1, "R13 disc");
        rd_intr("R13");
        cmd(8'h11, "R13 idle after");
        // R11 chip reset
        cmd(8'h43, "R11 sel");
        step(0, 2'd0, 8'h00, 0, 1, 0, "R11 done");
        cmd(8'h05, "R11 undef");
        cmd(8'h02, "R11 chiprst");
        rd_intr("R11");
        cmd(8'h12, "R11 idle after");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom % 10;
            case (k)
                0, 1, 2, 3: begin
                    logic [7:0] b;
                    b = ($urandom % 3 == 0) ? 8'($urandom) : picks[$urandom % 12];
                    if ($urandom % 2) b[7] = 1'b1;
                    cmd(b, "R8 rand cmd");
                end
                4: rd_intr("R10 rand");
                5: step(0, 2'd1, 8'h00, 1, 0, 0, "R10 rand");
                6: step(0, 2'd0, 8'h00, 0, 1, 0, "R12 rand");
                7: if ($urandom % 3 == 0) step(0, 2'd0, 8'h00, 0, 0, 1, "R13 rand");
                8: step(1, 2'd3, {1'b0, 1'($urandom), 6'b0}, 0, 0, 0, "R3 rand cfg");
                default: begin
                    phase_in = 3'($urandom);
                    step(0, 2'd0, 8'h00, 0, 0, 0, "R5 rand phase");
                end
            endcase
        end
        rd_intr("R10 final");
        finish_run();
    end
endmodule